// File: doc/BRIEF.md
# Carry and Overflow Flag Adder

This block is the add/subtract slice of a processor's integer unit. Two operands arrive from the register file: a source operand `rm` and a destination operand `rn`. The unit returns a result that the surrounding datapath writes back to the destination register. It also owns a single status bit, the T flag.

For the carry and borrow operations, T is both an input and an output. The incoming T is the carry-in or borrow-in, and the new T is the carry or borrow produced by the operation. For the overflow-detecting operations, the incoming T is ignored and T records signed overflow instead. One operation negates `rm` with a borrow. Together with subtract-with-borrow, it lets software build wide arithmetic out of 32-bit words.

The result is a purely combinational function of the operands, the operation select and the current T. T itself changes only on a clock edge on which the valid strobe is high.

Top module: `tflag_alu`

## Requirements
- R1: With `op` = 0 (add with carry), `result` = (rn + rm + T) mod 2^W. After a valid edge, T is 1 exactly when the full sum rn + rm + T is at least 2^W.
- R2: With `op` = 2 (subtract with borrow), `result` = (rn - rm - T) mod 2^W. After a valid edge, T is 1 exactly when rn - rm - T is negative.
- R3: With `op` = 4 (negate with borrow), `result` = (0 - rm - T) mod 2^W. After a valid edge, T is 1 exactly when rm is nonzero or the old T was 1.
- R4: With `op` = 1 (add, overflow detect), `result` = (rn + rm) mod 2^W whatever T is. After a valid edge, T is 1 exactly when rn and rm have equal sign bits and the result's sign bit differs from them.
- R5: With `op` = 3 (subtract, overflow detect), `result` = (rn - rm) mod 2^W whatever T is. After a valid edge, T is 1 exactly when the sign bits of rn and rm differ and the result's sign bit differs from that of rn.
- R6: `op` values 5, 6 and 7 drive `result` to zero and leave T unchanged, even with `valid` high.
- R7: T changes only on a rising clock edge with `valid` high. With `valid` low, T holds and `result` still follows the inputs.
- R8: An active-low `rst_n` clears T to 0 at once, without waiting for a clock edge.
- R9: `result` reflects the current T in the same cycle, with no register between the inputs and `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; T updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of T |
| valid | input | 1 | Qualifies the operation; T is written only when high |
| op | input | 3 | Operation select (0 addc, 1 addv, 2 subc, 3 subv, 4 negc) |
| rm | input | W | Source operand |
| rn | input | W | Destination operand |
| result | output | W | Value to write back to the destination register |
| t_flag | output | 1 | Current T flag |

## Verification
The assertions check, on every cycle, the following:
- T holds whenever `valid` is low or the select is unused.
- An unused select yields a zero result.
- Add-with-carry and add-with-overflow produce the expected sums from the live operands and T.
- A negate of a nonzero operand always sets T.

Only the bench scenarios can show the rest, because those cases need chosen operand values:
- The exact carry and borrow boundaries: a sum of exactly 2^W, a subtraction landing on minus one, and a negate of zero with T set.
- Signed overflow at the most negative and most positive values.
- The asynchronous clear of T in the middle of a run.

// File: rtl/tfa_pkg.sv
package tfa_pkg;

    typedef enum logic [2:0] {
        OP_ADDC = 3'd0,
        OP_ADDV = 3'd1,
        OP_SUBC = 3'd2,
        OP_SUBV = 3'd3,
        OP_NEGC = 3'd4
    } tfa_op_e;

    // How the new T is derived from the adder outputs
    typedef enum logic [1:0] {
        FK_HOLD   = 2'd0,
        FK_CARRY  = 2'd1,
        FK_BORROW = 2'd2,
        FK_OVF    = 2'd3
    } tfa_flag_kind_e;

endpackage

// File: rtl/tfa_opsel.sv
module tfa_opsel
    import tfa_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]      op,
    input  logic [W-1:0]    rn,
    input  logic [W-1:0]    rm,
    input  logic            t_cur,
    output logic [W-1:0]    opa,
    output logic [W-1:0]    opb,
    output logic            cin,
    output tfa_flag_kind_e  kind,
    output logic            known
);

    // Subtraction is addition of the inverted operand; a borrow-in of T
    // becomes a carry-in of ~T.
    always_comb begin
        opa   = rn;
        opb   = rm;
        cin   = 1'b0;
        kind  = FK_HOLD;
        known = 1'b1;
        case (op)
            OP_ADDC: begin
                cin  = t_cur;
                kind = FK_CARRY;
            end
            OP_ADDV: begin
                kind = FK_OVF;
            end
            OP_SUBC: begin
                opb  = ~rm;
                cin  = ~t_cur;
                kind = FK_BORROW;
            end
            OP_SUBV: begin
                opb  = ~rm;
                cin  = 1'b1;
                kind = FK_OVF;
            end
            OP_NEGC: begin
                opa  = '0;
                opb  = ~rm;
                cin  = ~t_cur;
                kind = FK_BORROW;
            end
            default: begin
                opa   = '0;
                opb   = '0;
                known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tfa_adder.sv
module tfa_adder #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int WX = W + 1;

    generate
        if (RIPPLE) begin : g_ripple
            logic [W:0] c;
            assign c[0] = cin;
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign sum[i]   = a[i] ^ b[i] ^ c[i];
                assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
            end
            assign cout = c[W];
        end else begin : g_infer
            logic [WX-1:0] wide;
            assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            assign sum  = wide[W-1:0];
            assign cout = wide[W];
        end
    endgenerate

endmodule

// File: rtl/tfa_flag.sv
module tfa_flag
    import tfa_pkg::*;
(
    input  tfa_flag_kind_e kind,
    input  logic           cout,
    input  logic           a_msb,
    input  logic           b_msb,
    input  logic           s_msb,
    input  logic           t_cur,
    output logic           t_new
);

    always_comb begin
        case (kind)
            FK_CARRY:  t_new = cout;
            FK_BORROW: t_new = ~cout;
            FK_OVF:    t_new = (a_msb == b_msb) && (s_msb != a_msb);
            default:   t_new = t_cur;
        endcase
    end

endmodule

// File: rtl/tflag_alu.sv
module tflag_alu
    import tfa_pkg::*;
#(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic [2:0]   op,
    input  logic [W-1:0] rm,
    input  logic [W-1:0] rn,
    output logic [W-1:0] result,
    output logic         t_flag
);

    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         t;
    } tfa_next_t;

    logic           t_q;
    tfa_next_t      nxt_d;

    logic [W-1:0]   opa, opb, sum;
    logic           cin, cout, known, t_calc;
    tfa_flag_kind_e kind;

    tfa_opsel #(.W(W)) u_opsel (
        .op    (op),
        .rn    (rn),
        .rm    (rm),
        .t_cur (t_q),
        .opa   (opa),
        .opb   (opb),
        .cin   (cin),
        .kind  (kind),
        .known (known)
    );

    tfa_adder #(.W(W), .RIPPLE(RIPPLE)) u_adder (
        .a    (opa),
        .b    (opb),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    tfa_flag u_flag (
        .kind  (kind),
        .cout  (cout),
        .a_msb (opa[MSB]),
        .b_msb (opb[MSB]),
        .s_msb (sum[MSB]),
        .t_cur (t_q),
        .t_new (t_calc)
    );

    always_comb begin
        nxt_d.res = known ? sum : '0;
        nxt_d.t   = valid ? t_calc : t_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= 1'b0;
        end else begin
            t_q <= nxt_d.t;
        end
    end

    assign result = nxt_d.res;
    assign t_flag = t_q;

endmodule

// File: rtl/tflag_alu_chk.sv
module tflag_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid,
    input logic [2:0]   op,
    input logic [W-1:0] rm,
    input logic [W-1:0] rn,
    input logic [W-1:0] result,
    input logic         t_flag
);

    logic [W-1:0] t_ext;
    assign t_ext = {{(W-1){1'b0}}, t_flag};

    // R7: no write without the strobe
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(t_flag));

    // R6: unused selects keep T
    a_r6_unused_keeps_t: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op > 3'd4) |=> $stable(t_flag));

    // R6: unused selects give a zero result
    a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 3'd4) |-> (result == '0));

    // R1 and R9: sum with the live T
    a_r1_addc_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0) |-> (result == W'(rn + rm + t_ext)));

    // R4: T does not enter the sum
    a_r4_addv_no_t: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1) |-> (result == W'(rn + rm)));

    // R3: negating a nonzero operand always sets T
    a_r3_negc_sets_t: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 3'd4 && rm != '0) |=> t_flag);

endmodule

bind tflag_alu tflag_alu_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (valid),
    .op     (op),
    .rm     (rm),
    .rn     (rn),
    .result (result),
    .t_flag (t_flag)
);

// File: tb/tflag_alu_tb.sv
`timescale 1ns/1ps
module tflag_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] rm = '0;
    logic [31:0] rn = '0;
    logic [31:0] result;
    logic        t_flag;

    int checks = 0;
    int errors = 0;
    bit model_t = 1'b0;

    always #2.5 clk = ~clk;

    tflag_alu #(.W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .op(op),
        .rm(rm), .rn(rn), .result(result), .t_flag(t_flag)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: returns expected result and next T
    task automatic ref_op(input logic [2:0] o, input logic [31:0] a_m,
                          input logic [31:0] a_n, input bit t,
                          output logic [31:0] r, output bit nt, output string req);
        longint un, um, s;
        longint sn, sm;
        un = longint'({32'b0, a_n});
        um = longint'({32'b0, a_m});
        sn = longint'($signed(a_n));
        sm = longint'($signed(a_m));
        case (o)
            3'd0: begin s = un + um + t; r = s[31:0]; nt = (s >= 64'sh1_0000_0000); req = "R1"; end
            3'd1: begin s = sn + sm; r = s[31:0];
                  nt = (s > 64'sh7fff_ffff) || (s < -64'sh8000_0000); req = "R4"; end
            3'd2: begin s = un - um - t; r = s[31:0]; nt = (s < 0); req = "R2"; end
            3'd3: begin s = sn - sm; r = s[31:0];
                  nt = (s > 64'sh7fff_ffff) || (s < -64'sh8000_0000); req = "R5"; end
            3'd4: begin s = 0 - um - t; r = s[31:0]; nt = (s < 0); req = "R3"; end
            default: begin r = '0; nt = t; req = "R6"; end
        endcase
    endtask

    task automatic step(input logic [2:0] o, input logic [31:0] a_m,
                        input logic [31:0] a_n, input bit v);
        logic [31:0] er;
        bit          nt;
        string       req;
        @(negedge clk);
        op = o; rm = a_m; rn = a_n; valid = v;
        #1;
        ref_op(o, a_m, a_n, model_t, er, nt, req);
        chk({req, " R9 result"}, longint'(result), longint'(er));
        @(posedge clk);
        if (v) model_t = nt;
        #1;
        chk(v ? {req, " T"} : "R7 T hold", longint'(t_flag), longint'(model_t));
    endtask

    task automatic set_t(input bit v);
        // ADDV of 0x7fffffff + 1 overflows; 0 + 0 does not
        step(3'd1, v ? 32'h1 : 32'h0, v ? 32'h7fff_ffff : 32'h0, 1'b1);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3;
        chk("R8 reset T", longint'(t_flag), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 carry boundaries
        set_t(0); step(3'd0, 32'hffff_ffff, 32'h1, 1);
        step(3'd0, 32'h0, 32'h0, 1);
        set_t(1); step(3'd0, 32'hffff_ffff, 32'h0, 1);
        set_t(1); step(3'd0, 32'h1234, 32'h1, 1);
        // R2 borrow boundaries
        set_t(0); step(3'd2, 32'h1, 32'h0, 1);
        set_t(1); step(3'd2, 32'h5, 32'h5, 1);
        set_t(1); step(3'd2, 32'h5, 32'h6, 1);
        // R3 negate corners
        set_t(0); step(3'd4, 32'h0, 32'h0, 1);
        set_t(1); step(3'd4, 32'h0, 32'h0, 1);
        set_t(0); step(3'd4, 32'h8000_0000, 32'h0, 1);
        // R4 overflow, T ignored in the result
        set_t(1); step(3'd1, 32'h8000_0000, 32'h8000_0000, 1);
        set_t(1); step(3'd1, 32'h1, 32'h2, 1);
        // R5 overflow
        set_t(1); step(3'd3, 32'h1, 32'h8000_0000, 1);
        step(3'd3, 32'hffff_ffff, 32'h7fff_ffff, 1);
        set_t(1); step(3'd3, 32'h3, 32'h9, 1);
        // R6 unused selects with T = 1 and T = 0
        set_t(1); step(3'd5, 32'hffff_ffff, 32'h1, 1);
        step(3'd6, 32'h0, 32'h0, 1);
        set_t(0); step(3'd7, 32'hffff_ffff, 32'hffff_ffff, 1);
        // R7 strobe low: carry would set T, must hold
        set_t(0); step(3'd0, 32'hffff_ffff, 32'hffff_ffff, 0);
        set_t(1); step(3'd1, 32'h0, 32'h0, 0);

        // mixed random traffic
        for (int i = 0; i < 2000; i++) begin
            step(3'($urandom_range(0, 7)), $urandom, $urandom, 1'($urandom));
        end

        // R8 asynchronous clear mid-run
        set_t(1);
        @(negedge clk);
        valid = 1'b0;
        #1 rst_n = 1'b0;
        #0.5;
        chk("R8 async clear", longint'(t_flag), 0);
        model_t = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(3'd0, 32'h1, 32'h1, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule